// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the array address for a synchronous SRAM that supports short bursts. A burst begins when either of two start strobes is sampled high: one comes from the processor side and one from the cache-controller side. At that edge the full external address is captured. The upper bits stay fixed for the rest of the burst. The two low bits then step through a four-beat sequence, moving one step on each cycle in which the advance strobe is high.

A static order-select input chooses one of two sequences for the low bits. Linear order counts upward and wraps modulo four. Interleaved order XORs the starting low bits with a running beat count.

Bursting is optional. A host can raise a start strobe on every cycle, and each new address is then presented one cycle later with no gap. A start strobe that arrives while either chip select is low deselects the block and leaves the address unchanged.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high, and at the first sampling point after it, `mem_addr` is 0, `busy` is 0 and `from_ctl` is 0.
- R2: When a start strobe is sampled high and both `sel_a` and `sel_b` are high, `mem_addr` equals the sampled `addr_in` one clock later and `busy` is 1.
- R3: When both start strobes are high in the same enabled cycle, the processor strobe wins and `from_ctl` becomes 0. When only `start_ctl` is high, `from_ctl` becomes 1.
- R4: A start strobe sampled while `sel_a` or `sel_b` is low makes `busy` 0 one clock later. In that case `mem_addr` and `from_ctl` keep their previous values.
- R5: With `order_sel`=0 (linear), each advance adds 1 modulo 4 to `mem_addr[1:0]`. The upper bits never change inside a burst, so there is no carry out of bit 1.
- R6: With `order_sel`=1 (interleaved), beat n of a burst has low bits equal to the starting low bits XOR n, for n = 0, 1, 2, 3.
- R7: In a cycle with no start strobe and `adv` low, `mem_addr` is unchanged one clock later.
- R8: After four advances the low bits return to their starting value, and further advances repeat the same sequence.
- R9: `adv` has no effect while `busy` is 0.
- R10: A start strobe on every consecutive cycle loads a new address every cycle, and each address appears one clock after it was sampled.
- R11: A start strobe overrides `adv` in the same cycle: the burst restarts at beat 0 from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | External address captured at a burst start |
| start_cpu | input | 1 | Processor-side burst start strobe (higher priority) |
| start_ctl | input | 1 | Controller-side burst start strobe |
| adv | input | 1 | Advance strobe that steps the beat counter |
| sel_a | input | 1 | Chip select A, active high |
| sel_b | input | 1 | Chip select B, active high |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| mem_addr | output | ADDR_W | Registered array address |
| busy | output | 1 | High while a burst or single access is selected |
| from_ctl | output | 1 | High when the current burst was started by the controller strobe |

## Verification
The assertions check four things on every cycle. An enabled start loads the sampled address. A start with a chip select low deselects and leaves the address frozen. The processor strobe always wins. With neither a start nor an advance, the address does not move, and the upper bits never drift inside a burst. The exact linear and interleaved sequences, the wrap after four advances, the ignored advance while deselected, and back-to-back loading on every cycle are only shown by the bench's scenarios, which compare each beat with values worked out by hand.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // Low-address bits for a given start value and beat index.
  function automatic logic [1:0] beat_low(input order_e ord,
                                          input logic [1:0] base,
                                          input logic [1:0] beat);
    if (ord == ORD_INTERLEAVE) beat_low = base ^ beat;
    else                       beat_low = base + beat;
  endfunction

endpackage

// File: rtl/start_arbiter.sv
module start_arbiter (
  input  logic start_cpu,
  input  logic start_ctl,
  input  logic sel_a,
  input  logic sel_b,
  output logic load,
  output logic desel,
  output logic src_ctl
);
  logic any_start;
  logic chip_on;

  always_comb begin
    any_start = start_cpu | start_ctl;
    chip_on   = sel_a & sel_b;
    load      = any_start & chip_on;
    desel     = any_start & ~chip_on;
    // the processor strobe takes precedence over the controller strobe
    src_ctl   = start_ctl & ~start_cpu;
  end
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] beat_d
);
  always_comb begin
    if (load)      beat_d = '0;
    else if (step) beat_d = beat_q + BEAT_W'(1);
    else           beat_d = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_d;
  end

  a_r8_step_mod: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> beat_q == BEAT_W'($past(beat_q) + BEAT_W'(1)))
    else $error("R8 beat step");
endmodule

// File: rtl/low_mapper.sv
module low_mapper
  import burst_seq_pkg::*;
(
  input  order_e     ord,
  input  logic [1:0] base,
  input  logic [1:0] beat,
  output logic [1:0] low
);
  always_comb low = beat_low(ord, base, beat);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              start_cpu,
  input  logic              start_ctl,
  input  logic              adv,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              busy,
  output logic              from_ctl
);
  localparam int BEAT_W = 2;
  localparam int UP_W   = ADDR_W - BEAT_W;

  logic              load, desel, src_ctl, step;
  logic [UP_W-1:0]   upper_q, upper_d;
  logic [1:0]        base_q, base_d;
  logic [1:0]        beat_q, beat_d;
  logic [1:0]        low_d;
  order_e            ord;

  start_arbiter u_arb (
    .start_cpu (start_cpu),
    .start_ctl (start_ctl),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .load      (load),
    .desel     (desel),
    .src_ctl   (src_ctl)
  );

  always_comb step = adv & busy & ~(start_cpu | start_ctl);

  beat_counter #(.BEAT_W(BEAT_W)) u_beat (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .step   (step),
    .beat_q (beat_q),
    .beat_d (beat_d)
  );

  always_comb begin
    ord     = order_e'(order_sel);
    upper_d = load ? addr_in[ADDR_W-1:BEAT_W] : upper_q;
    base_d  = load ? addr_in[BEAT_W-1:0]      : base_q;
  end

  low_mapper u_map (
    .ord  (ord),
    .base (base_d),
    .beat (beat_d),
    .low  (low_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q  <= '0;
      base_q   <= '0;
      mem_addr <= '0;
      busy     <= 1'b0;
      from_ctl <= 1'b0;
    end else begin
      upper_q <= upper_d;
      base_q  <= base_d;
      if (load || step) mem_addr <= {upper_d, low_d};
      if (load) begin
        busy     <= 1'b1;
        from_ctl <= src_ctl;
      end else if (desel) begin
        busy     <= 1'b0;
      end
    end
  end

  a_r2_load_addr: assert property (@(posedge clk) disable iff (rst)
    ((start_cpu || start_ctl) && sel_a && sel_b) |=> (mem_addr == $past(addr_in)) && busy)
    else $error("R2 load");

  a_r3_cpu_wins: assert property (@(posedge clk) disable iff (rst)
    (start_cpu && sel_a && sel_b) |=> !from_ctl)
    else $error("R3 priority");

  a_r4_desel_frozen: assert property (@(posedge clk) disable iff (rst)
    ((start_cpu || start_ctl) && !(sel_a && sel_b)) |=> !busy && $stable(mem_addr) && $stable(from_ctl))
    else $error("R4 deselect");

  a_r7_no_adv_hold: assert property (@(posedge clk) disable iff (rst)
    (!start_cpu && !start_ctl && !adv) |=> $stable(mem_addr))
    else $error("R7 hold");

  a_r5_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (!start_cpu && !start_ctl) |=> $stable(mem_addr[ADDR_W-1:BEAT_W]))
    else $error("R5 upper");
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr_in;
  logic          start_cpu, start_ctl, adv, sel_a, sel_b, order_sel;
  logic [AW-1:0] mem_addr;
  logic          busy, from_ctl;
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .start_cpu(start_cpu),
    .start_ctl(start_ctl), .adv(adv), .sel_a(sel_a), .sel_b(sel_b),
    .order_sel(order_sel), .mem_addr(mem_addr), .busy(busy), .from_ctl(from_ctl)
  );

  typedef struct packed {
    logic          cpu, ctl, ad, ea, eb, ord;
    logic [AW-1:0] a;
    logic [AW-1:0] x_addr;
    logic          x_busy, x_src;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1,0,0,1,1,0, 18'h12346, 18'h12346, 1,0}, // R2 cpu start
    '{0,0,1,1,1,0, 18'h0,     18'h12347, 1,0}, // R5
    '{0,0,1,1,1,0, 18'h0,     18'h12344, 1,0}, // R5 wrap in low bits
    '{0,0,0,1,1,0, 18'h0,     18'h12344, 1,0}, // R7
    '{0,0,1,1,1,0, 18'h0,     18'h12345, 1,0}, // R5
    '{0,0,1,1,1,0, 18'h0,     18'h12346, 1,0}, // R8 back to start
    '{0,0,1,1,1,0, 18'h0,     18'h12347, 1,0}, // R8 beyond four
    '{0,1,0,1,1,1, 18'h0ABC1, 18'h0ABC1, 1,1}, // R3 ctl alone
    '{0,0,1,1,1,1, 18'h0,     18'h0ABC0, 1,1}, // R6 1^1
    '{0,0,1,1,1,1, 18'h0,     18'h0ABC3, 1,1}, // R6 1^2
    '{0,0,1,1,1,1, 18'h0,     18'h0ABC2, 1,1}, // R6 1^3
    '{0,0,1,1,1,1, 18'h0,     18'h0ABC1, 1,1}, // R8 interleave wrap
    '{1,1,0,1,1,0, 18'h3FFFF, 18'h3FFFF, 1,0}, // R3 both strobes
    '{0,0,1,1,1,0, 18'h0,     18'h3FFFC, 1,0}, // R5 no carry
    '{1,0,0,1,0,0, 18'h00001, 18'h3FFFC, 0,0}, // R4 sel_b low
    '{0,0,1,1,1,0, 18'h0,     18'h3FFFC, 0,0}, // R9 adv ignored
    '{0,1,0,0,1,0, 18'h00005, 18'h3FFFC, 0,0}, // R4 sel_a low
    '{1,0,1,1,1,0, 18'h00010, 18'h00010, 1,0}, // R11 start beats adv
    '{1,0,0,1,1,0, 18'h00111, 18'h00111, 1,0}, // R10
    '{1,0,0,1,1,0, 18'h00222, 18'h00222, 1,0}, // R10
    '{1,0,0,1,1,0, 18'h00333, 18'h00333, 1,0}, // R10
    '{0,1,1,1,1,0, 18'h0002A, 18'h0002A, 1,1}  // R11 ctl start with adv
  };

  task automatic chk(input string tag, input logic [AW-1:0] xa,
                     input logic xb, input logic xs);
    total++;
    if (mem_addr !== xa || busy !== xb || from_ctl !== xs) begin
      bad++;
      $display("FAIL %s: got addr=%h busy=%0b src=%0b, expected addr=%h busy=%0b src=%0b",
               tag, mem_addr, busy, from_ctl, xa, xb, xs);
    end
  endtask

  task automatic idle_inputs();
    start_cpu = 0; start_ctl = 0; adv = 0; sel_a = 1; sel_b = 1;
    order_sel = 0; addr_in = '0;
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 in reset", '0, 0, 0);
    rst = 0;
    adv = 1; // R9: advance right after reset, nothing selected
    @(posedge clk); @(negedge clk);
    chk("R1 after reset", '0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      start_cpu = VEC[i].cpu; start_ctl = VEC[i].ctl; adv = VEC[i].ad;
      sel_a = VEC[i].ea; sel_b = VEC[i].eb; order_sel = VEC[i].ord;
      addr_in = VEC[i].a;
      @(posedge clk); @(negedge clk);
      chk($sformatf("vector %0d", i), VEC[i].x_addr, VEC[i].x_busy, VEC[i].x_src);
    end

    // R6: interleave from base 2 -> 2,3,0,1
    idle_inputs();
    start_ctl = 1; order_sel = 1; addr_in = 18'h00F02;
    @(posedge clk); @(negedge clk);
    chk("R6 start", 18'h00F02, 1, 1);
    start_ctl = 0; adv = 1;
    @(posedge clk); @(negedge clk);
    chk("R6 beat1", 18'h00F03, 1, 1);
    @(posedge clk); @(negedge clk);
    chk("R6 beat2", 18'h00F00, 1, 1);
    @(posedge clk); @(negedge clk);
    chk("R6 beat3", 18'h00F01, 1, 1);

    // R7: long hold with adv low
    adv = 0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R7 long hold", 18'h00F01, 1, 1);

    // R1: reset mid-burst
    rst = 1;
    @(posedge clk); @(negedge clk);
    chk("R1 mid-burst reset", '0, 0, 0);
    rst = 0;
    @(posedge clk); @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule